// File: doc/BRIEF.md
# Local Interrupt Controller Base and Mode Register

This block holds the 32-bit base-and-mode control register of one core's local interrupt controller. Software writes the register through a simple strobe-and-data port. The upper twenty bits keep the address of the controller's register window. Two enable bits select the operating mode: disabled, legacy or extended. A capability input limits which of those enable bits a write may set. Bits it does not allow are stored as zero.

The register decodes its enable bits into a mode and shows that mode on an output. A write that changes the decoded mode produces a one-cycle pulse that carries the new mode. When a write moves the controller into the disabled mode, the block also clears the software-enable bit of the spurious-vector register and drops the pending-interrupt flag. The bootstrap-processor flag cannot be written. It is set from the hardwired core identifier at reset.

Top module: `lapic_base_reg`

## Requirements
- R1: After reset the register reads 0xFEE00800, plus 0x100 when core_id_i is zero. svr_o is 0x0FF, irq_pend_o is 0 and mode_o is legacy (01).
- R2: A write replaces bits 31:12 with bits 31:12 of wr_data_i. Bits 9 and 7:0 always read as zero.
- R3: cap_i limits the stored enable bits. 00 (none) allows neither bit. 01 (legacy) allows only bit 11. 10 (extended) allows bits 11 and 10. 11 behaves as none. Any enable bit that is not allowed is stored as zero on a write.
- R4: Bit 8 is set at reset exactly when core_id_i is zero. Writes never change it.
- R5: mode_o decodes bits 11:10 of the register as follows: 00 gives disabled (00), 01 also gives disabled (00), 10 gives legacy (01), 11 gives extended (10).
- R6: If a write changes the decoded mode, mode_chg_o is high for exactly the one cycle after the write edge, and mode_chg_val_o carries the new mode. A write that leaves the decoded mode unchanged does not pulse. This includes a write that moves the bits between 01 and 00.
- R7: At the edge where a write moves the mode from non-disabled to disabled, svr_o bit 8 and irq_pend_o are cleared. This clear overrides an svr write or an irq_set_i in the same cycle. A write that keeps the mode disabled clears neither.
- R8: The register changes only on a clock edge with wr_en_i high. rd_data_o shows the current value combinationally.
- R9: svr_we_i loads svr_wdata_i into svr_o, and irq_set_i sets irq_pend_o. Otherwise both hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| core_id_i | input | ID_W | Hardwired core identifier |
| cap_i | input | 2 | Capability level: 00 none, 01 legacy, 10 extended, 11 none |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Current register value |
| mode_o | output | 2 | Decoded mode: 00 disabled, 01 legacy, 10 extended |
| mode_chg_o | output | 1 | One-cycle mode-transition pulse |
| mode_chg_val_o | output | 2 | New mode that goes with the pulse |
| svr_we_i | input | 1 | Spurious-vector register write strobe |
| svr_wdata_i | input | SVR_W | Spurious-vector write data |
| svr_o | output | SVR_W | Spurious-vector register value |
| irq_set_i | input | 1 | Raises the pending-interrupt flag |
| irq_pend_o | output | 1 | Pending-interrupt flag |

## Verification
A wrong stored enable bit shows on rd_data_o and mode_o in the cycle after the faulty write. A wrong mode comparison shows as a missing or extra mode_chg_o pulse in that same cycle. A clear that is missed on entry to the disabled mode leaves svr_o bit 8 or irq_pend_o set at the next sample. A clear that fires when it should not drops them during a write from disabled to disabled. Every transition is therefore visible one cycle after its write edge, and the bench checks exactly that cycle.

// File: rtl/lapic_base_pkg.sv
package lapic_base_pkg;
  typedef enum logic [1:0] {
    MODE_DIS = 2'b00,
    MODE_LEG = 2'b01,
    MODE_EXT = 2'b10
  } mode_e;

  typedef enum logic [1:0] {
    CAP_NONE = 2'b00,
    CAP_LEG  = 2'b01,
    CAP_EXT  = 2'b10,
    CAP_RSVD = 2'b11
  } cap_e;

  localparam int unsigned REG_W    = 32;
  localparam int unsigned BASE_LSB = 12;
  localparam int unsigned BASE_W   = REG_W - BASE_LSB;
  localparam int unsigned GEN_BIT  = 11;
  localparam int unsigned EXT_BIT  = 10;
  localparam int unsigned BSP_BIT  = 8;
endpackage

// File: rtl/lapic_cap_mask.sv
module lapic_cap_mask
  import lapic_base_pkg::*;
(
  input  logic [1:0] cap_i,
  output logic [1:0] allow_o  // [1]=global enable, [0]=extended enable
);
  always_comb begin
    unique case (cap_e'(cap_i))
      CAP_LEG: allow_o = 2'b10;
      CAP_EXT: allow_o = 2'b11;
      default: allow_o = 2'b00;  // none and reserved
    endcase
  end
endmodule

// File: rtl/lapic_mode_dec.sv
module lapic_mode_dec
  import lapic_base_pkg::*;
(
  input  logic [1:0] en_bits_i,  // {global, extended}
  output mode_e      mode_o
);
  always_comb begin
    unique case (en_bits_i)
      2'b10:   mode_o = MODE_LEG;
      2'b11:   mode_o = MODE_EXT;
      default: mode_o = MODE_DIS;  // 00, and invalid 01
    endcase
  end
endmodule

// File: rtl/lapic_mode_track.sv
module lapic_mode_track
  import lapic_base_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  mode_e cur_i,
  input  mode_e nxt_i,
  output logic  chg_o,
  output mode_e val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chg_o <= 1'b0;
      val_o <= MODE_LEG;
    end else begin
      chg_o <= wr_i && (nxt_i != cur_i);
      if (wr_i) val_o <= nxt_i;
    end
  end

  // after a pulse, the mode now held must be the announced one
  p_chg_val_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> (cur_i == val_o));
endmodule

// File: rtl/lapic_base_reg.sv
module lapic_base_reg
  import lapic_base_pkg::*;
#(
  parameter int unsigned         ID_W     = 8,
  parameter int unsigned         SVR_W    = 9,
  parameter logic [BASE_W-1:0]   RST_BASE = 20'hFEE00,
  parameter logic [SVR_W-1:0]    RST_SVR  = 9'h0FF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ID_W-1:0]  core_id_i,
  input  logic [1:0]       cap_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [1:0]       mode_o,
  output logic             mode_chg_o,
  output logic [1:0]       mode_chg_val_o,
  input  logic             svr_we_i,
  input  logic [SVR_W-1:0] svr_wdata_i,
  output logic [SVR_W-1:0] svr_o,
  input  logic             irq_set_i,
  output logic             irq_pend_o
);
  localparam int unsigned SVR_EN = SVR_W - 1;

  logic [BASE_W-1:0] base_q;
  logic [1:0]        en_q;
  logic              bsp_q;
  logic [1:0]        allow;
  logic [1:0]        en_nxt;
  mode_e             cur_mode, nxt_mode, chg_val;
  logic              dis_entry;
  logic [SVR_W-1:0]  svr_q, svr_d;
  logic              irq_q;

  lapic_cap_mask u_mask (.cap_i(cap_i), .allow_o(allow));

  assign en_nxt = wr_data_i[GEN_BIT:EXT_BIT] & allow;

  lapic_mode_dec u_dec_cur (.en_bits_i(en_q),   .mode_o(cur_mode));
  lapic_mode_dec u_dec_nxt (.en_bits_i(en_nxt), .mode_o(nxt_mode));

  assign dis_entry = wr_en_i && (nxt_mode == MODE_DIS) && (cur_mode != MODE_DIS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= RST_BASE;
      en_q   <= 2'b10;
      bsp_q  <= (core_id_i == '0);
    end else if (wr_en_i) begin
      base_q <= wr_data_i[REG_W-1:BASE_LSB];
      en_q   <= en_nxt;
    end
  end

  lapic_mode_track u_track (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (wr_en_i),
    .cur_i (cur_mode),
    .nxt_i (nxt_mode),
    .chg_o (mode_chg_o),
    .val_o (chg_val)
  );

  always_comb begin
    svr_d = svr_we_i ? svr_wdata_i : svr_q;
    if (dis_entry) svr_d[SVR_EN] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svr_q <= RST_SVR;
      irq_q <= 1'b0;
    end else begin
      svr_q <= svr_d;
      if (dis_entry)      irq_q <= 1'b0;
      else if (irq_set_i) irq_q <= 1'b1;
    end
  end

  assign rd_data_o      = {base_q, en_q, 1'b0, bsp_q, 8'h00};
  assign mode_o         = cur_mode;
  assign mode_chg_val_o = chg_val;
  assign svr_o          = svr_q;
  assign irq_pend_o     = irq_q;

  logic past_vld;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_vld <= 1'b0;
    else         past_vld <= 1'b1;
  end

  p_bsp_fixed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld |-> $stable(rd_data_o[BSP_BIT]));

  p_hold_no_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld && !$past(wr_en_i)) |-> $stable(rd_data_o));

  p_cap_none_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld && $past(wr_en_i) && ($past(cap_i) == CAP_NONE || $past(cap_i) == CAP_RSVD))
      |-> (rd_data_o[GEN_BIT:EXT_BIT] == 2'b00));

  p_chg_after_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld && mode_chg_o) |-> $past(wr_en_i));

  p_dis_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_chg_o && mode_chg_val_o == MODE_DIS) |-> (!irq_pend_o && !svr_o[SVR_EN]));
endmodule

// File: tb/tb_lapic_base_reg.sv
module tb_lapic_base_reg;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W  = 8;
  localparam int SVR_W = 9;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [ID_W-1:0]  core_id_i = '0;
  logic [1:0]       cap_i = 2'b01;
  logic             wr_en_i = 1'b0;
  logic [31:0]      wr_data_i = '0;
  logic [31:0]      rd_data_o;
  logic [1:0]       mode_o;
  logic             mode_chg_o;
  logic [1:0]       mode_chg_val_o;
  logic             svr_we_i = 1'b0;
  logic [SVR_W-1:0] svr_wdata_i = '0;
  logic [SVR_W-1:0] svr_o;
  logic             irq_set_i = 1'b0;
  logic             irq_pend_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lapic_base_reg #(.ID_W(ID_W), .SVR_W(SVR_W)) dut (.*);

  typedef struct packed {
    logic [1:0]  cap;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic [1:0]  exp_mode;
    logic        exp_chg;
  } vec_t;

  // core_id 0: bit 8 always reads set
  localparam vec_t VEC [10] = '{
    '{2'b10, 32'hFEE00C00, 32'hFEE00D00, 2'b10, 1'b1},  // R3 R6 to extended
    '{2'b10, 32'hABCDEDFF, 32'hABCDED00, 2'b10, 1'b0},  // R2 R4 no change
    '{2'b01, 32'hFEE00C00, 32'hFEE00900, 2'b01, 1'b1},  // R3 legacy masks bit 10
    '{2'b00, 32'hFEE00C00, 32'hFEE00100, 2'b00, 1'b1},  // R3 none
    '{2'b01, 32'h12345800, 32'h12345900, 2'b01, 1'b1},  // R2 R5
    '{2'b10, 32'h12345400, 32'h12345500, 2'b00, 1'b1},  // R5 invalid 01 = disabled
    '{2'b10, 32'h00000000, 32'h00000100, 2'b00, 1'b0},  // R6 01 -> 00 no pulse
    '{2'b11, 32'hFFFFFFFF, 32'hFFFFF100, 2'b00, 1'b0},  // R3 reserved as none
    '{2'b10, 32'hFFFFFFFF, 32'hFFFFFD00, 2'b10, 1'b1},  // R5 extended
    '{2'b10, 32'h00000800, 32'h00000900, 2'b01, 1'b1}   // R6 ext -> legacy
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write at one edge, sample at the following negedge
  task automatic do_wr(input logic [1:0] cap, input logic [31:0] data);
    @(negedge clk_i);
    cap_i = cap; wr_en_i = 1'b1; wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic do_reset(input logic [ID_W-1:0] id);
    @(negedge clk_i);
    core_id_i = id; rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset('0);
    chk("R1 rd", rd_data_o, 32'hFEE00900);
    chk("R1 mode", {30'd0, mode_o}, 32'd1);
    chk("R1 svr", {23'd0, svr_o}, 32'h0FF);
    chk("R1 irq", {31'd0, irq_pend_o}, 32'd0);
    chk("R1 chg", {31'd0, mode_chg_o}, 32'd0);

    for (int i = 0; i < 10; i++) begin
      do_wr(VEC[i].cap, VEC[i].wdata);
      chk("R2/R3 rd", rd_data_o, VEC[i].exp_rd);
      chk("R5 mode", {30'd0, mode_o}, {30'd0, VEC[i].exp_mode});
      chk("R6 chg", {31'd0, mode_chg_o}, {31'd0, VEC[i].exp_chg});
      if (VEC[i].exp_chg)
        chk("R6 val", {30'd0, mode_chg_val_o}, {30'd0, VEC[i].exp_mode});
      @(negedge clk_i);
      chk("R6 one cycle", {31'd0, mode_chg_o}, 32'd0);
    end

    // R8: data toggles without strobe leave register unchanged
    @(negedge clk_i);
    cap_i = 2'b10; wr_data_i = 32'h55555C00;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R8 hold", rd_data_o, 32'h00000900);
    chk("R8 no pulse", {31'd0, mode_chg_o}, 32'd0);

    // R9: svr write and irq set
    @(negedge clk_i);
    svr_we_i = 1'b1; svr_wdata_i = 9'h1A5; irq_set_i = 1'b1;
    @(negedge clk_i);
    svr_we_i = 1'b0; irq_set_i = 1'b0;
    chk("R9 svr", {23'd0, svr_o}, 32'h1A5);
    chk("R9 irq", {31'd0, irq_pend_o}, 32'd1);

    // R7: entry to disabled clears
    do_wr(2'b00, 32'hFEE00000);
    chk("R7 svr clr", {23'd0, svr_o}, 32'h0A5);
    chk("R7 irq clr", {31'd0, irq_pend_o}, 32'd0);

    // R7: disabled -> disabled clears nothing
    @(negedge clk_i);
    svr_we_i = 1'b1; svr_wdata_i = 9'h1FF; irq_set_i = 1'b1;
    @(negedge clk_i);
    svr_we_i = 1'b0; irq_set_i = 1'b0;
    do_wr(2'b10, 32'hFEE00400);
    chk("R7 no clr svr", {23'd0, svr_o}, 32'h1FF);
    chk("R7 no clr irq", {31'd0, irq_pend_o}, 32'd1);
    chk("R7 no pulse", {31'd0, mode_chg_o}, 32'd0);

    // R7: same-cycle set/write loses to the clear
    do_wr(2'b01, 32'hFEE00800);
    chk("R7 relegacy", {30'd0, mode_o}, 32'd1);
    @(negedge clk_i);
    cap_i = 2'b01; wr_en_i = 1'b1; wr_data_i = 32'hFEE00000;
    svr_we_i = 1'b1; svr_wdata_i = 9'h1C3; irq_set_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; svr_we_i = 1'b0; irq_set_i = 1'b0;
    chk("R7 override svr", {23'd0, svr_o}, 32'h0C3);
    chk("R7 override irq", {31'd0, irq_pend_o}, 32'd0);

    // R4: nonzero core id, bit 8 clear and unwritable
    do_reset(8'd3);
    chk("R4 rst", rd_data_o, 32'hFEE00800);
    do_wr(2'b10, 32'hFEE00DFF);
    chk("R4 no write", rd_data_o, 32'hFEE00C00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule